// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a true dual-port synchronous static memory. It has two ports, A and B, and each has its own clock. Either port can read or write any word at any time. A word is 18 bits wide and is split into two 9-bit lanes. Bits 8:0 form the lower lane and bits 17:9 form the upper lane.

Each port has its own controls:
- A select pair made of one active-low input and one active-high input.
- A read-not-write strobe.
- An active-low enable for each lane.
- An asynchronous active-low output enable.

A write changes only the lanes whose enable is asserted. A read is captured at the clock edge and appears at the outputs one cycle later. The output stage is not a tristate pad. Instead, each port presents a per-lane drive flag next to its read-data bus, and a lane whose flag is low reads as zero.

Storage uses two banks, one written only by each port. A per-word, per-lane tag table records which port wrote the word last, so no array has two writers. The address width `ADDR_W` defaults to 8 so that simulation stays small. A full-size 64K-word part uses `ADDR_W = 16`.

Top module: `dual_lane_ram`

## Requirements
- R1: A port is selected at a rising edge of its clock only when `x_cs_n` is 0 and `x_cs` is 1. An unselected port writes nothing, and in the following cycle both of its drive flags are 0.
- R2: A selected port with `x_rnw` = 0 writes its `x_wdata` lanes into the word at `x_addr`. Only lanes whose `x_lane_en_n` bit is 0 are written: bit 0 controls bits 8:0 and bit 1 controls bits 17:9. A lane that is not written keeps its stored value.
- R3: When `x_lane_en_n` is 2'b11, a selected access neither writes nor drives any lane, whatever the value of `x_rnw`.
- R4: A selected port with `x_rnw` = 1 at edge k presents the word stored at `x_addr` on `x_rdata` after edge k. The value is held until edge k+1. `x_drive[i]` is 1 exactly for the lanes whose enable bit was 0 at edge k, provided `x_oe_n` is 0.
- R5: A lane whose drive flag is 0 reads as zero on `x_rdata`.
- R6: In the cycle after a write, both drive flags of that port are 0, whatever the level of `x_oe_n`.
- R7: While `x_oe_n` is 1, both drive flags are 0. When `x_oe_n` returns to 0, the flags of the registered read come back without any clock edge.
- R8: A word written by one port can be read by the other port on any later edge. Each lane returns the value from the most recent write to that lane by either port.
- R9: Accesses made on both ports at the same edge to different addresses do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_rnw | input | 1 | Port A read (1) or write (0) |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_lane_en_n | input | LANES | Port A lane enables, active low, bit 0 = lower lane |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A read data, zero in lanes not driven |
| a_drive | output | LANES | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_rnw | input | 1 | Port B read (1) or write (0) |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_lane_en_n | input | LANES | Port B lane enables, active low, bit 0 = lower lane |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B read data, zero in lanes not driven |
| b_drive | output | LANES | Port B per-lane drive flags |

## Verification
The assertions assume that every control input holds a known 0 or 1 at each clock edge. They also assume that the two ports never touch the same word at the same edge while either of them is writing. Under that overlap, both the stored value and the read result are undefined.

The stimulus drives all inputs away from the clock edge and starts from idle, fully defined values. In the mixed-traffic phase, whenever the two random addresses match, port B's address is changed, so no colliding access is ever produced.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;
  localparam int DEF_LANE_W = 9;
  localparam int DEF_LANES  = 2;

  // The two select inputs have opposite polarity.
  function automatic logic port_selected(input logic cs_n, input logic cs);
    return (cs_n == 1'b0) && (cs == 1'b1);
  endfunction

  // A lane takes part in an access when its active-low enable is 0.
  function automatic logic lane_active(input logic en_n);
    return en_n == 1'b0;
  endfunction

  // Port A copy is the newest when both tags agree.
  function automatic logic a_copy_newest(input logic tag_a, input logic tag_b);
    return tag_a == tag_b;
  endfunction
endpackage

// File: rtl/dpbr_port_decode.sv
module dpbr_port_decode #(
  parameter int LANES = dpbr_pkg::DEF_LANES
) (
  input  logic             cs_n,
  input  logic             cs,
  input  logic             rnw,
  input  logic [LANES-1:0] lane_en_n,
  output logic             sel,
  output logic [LANES-1:0] wr_lanes,
  output logic [LANES-1:0] rd_lanes
);
  assign sel = dpbr_pkg::port_selected(cs_n, cs);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_lanes[l] = sel & ~rnw & dpbr_pkg::lane_active(lane_en_n[l]);
    assign rd_lanes[l] = sel &  rnw & dpbr_pkg::lane_active(lane_en_n[l]);
  end
endmodule

// File: rtl/dpbr_bank.sv
module dpbr_bank #(
  parameter int ADDR_W     = 8,
  parameter int LANE_W     = dpbr_pkg::DEF_LANE_W,
  parameter bit INVERT_TAG = 1'b0
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] peer_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              peer_tag_at_own,
  output logic [LANE_W-1:0] own_data,
  output logic              own_tag,
  output logic [LANE_W-1:0] peer_data,
  output logic              peer_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] data_mem [DEPTH];
  logic              tag_mem  [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      data_mem[i] = '0;
      tag_mem[i]  = 1'b0;
    end
  end

  // Only the owning port writes this bank. The stored tag marks which
  // copy is the newest when compared with the other bank's tag.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[own_addr] <= wr_data;
      tag_mem[own_addr]  <= peer_tag_at_own ^ INVERT_TAG;
    end
  end

  assign own_data  = data_mem[own_addr];
  assign own_tag   = tag_mem[own_addr];
  assign peer_data = data_mem[peer_addr];
  assign peer_tag  = tag_mem[peer_addr];
endmodule

// File: rtl/dpbr_read_pipe.sv
module dpbr_read_pipe #(
  parameter int LANE_W = dpbr_pkg::DEF_LANE_W,
  parameter int LANES  = dpbr_pkg::DEF_LANES,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic [LANES-1:0]  rd_lanes,
  input  logic [WORD_W-1:0] word_in,
  input  logic              oe_n,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  drive
);
  logic [LANES-1:0]  lane_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    lane_q <= rd_lanes;
    data_q <= word_in;
  end

  // The output enable gates the registered flags without waiting for a clock.
  assign drive = lane_q & {LANES{~oe_n}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdata[l*LANE_W +: LANE_W] = drive[l] ? data_q[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/dual_lane_ram.sv
module dual_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = dpbr_pkg::DEF_LANE_W,
  parameter int LANES  = dpbr_pkg::DEF_LANES,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              a_clk,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_rnw,
  input  logic              a_oe_n,
  input  logic [LANES-1:0]  a_lane_en_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic [LANES-1:0]  a_drive,
  input  logic              b_clk,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_rnw,
  input  logic              b_oe_n,
  input  logic [LANES-1:0]  b_lane_en_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic [LANES-1:0]  b_drive
);
  // Decode results, brought out as named events.
  logic             a_sel, b_sel;
  logic [LANES-1:0] a_wr_lanes, a_rd_lanes, b_wr_lanes, b_rd_lanes;

  // Bank contents and tags, viewed at each port's address.
  logic [LANES-1:0]  ta_own, ta_peer, tb_own, tb_peer;
  logic [WORD_W-1:0] da_own, da_peer, db_own, db_peer;
  logic [WORD_W-1:0] a_word, b_word;

  dpbr_port_decode #(.LANES(LANES)) u_dec_a (
    .cs_n(a_cs_n), .cs(a_cs), .rnw(a_rnw), .lane_en_n(a_lane_en_n),
    .sel(a_sel), .wr_lanes(a_wr_lanes), .rd_lanes(a_rd_lanes)
  );

  dpbr_port_decode #(.LANES(LANES)) u_dec_b (
    .cs_n(b_cs_n), .cs(b_cs), .rnw(b_rnw), .lane_en_n(b_lane_en_n),
    .sel(b_sel), .wr_lanes(b_wr_lanes), .rd_lanes(b_rd_lanes)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dpbr_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .INVERT_TAG(1'b0)) u_bank_a (
      .clk(a_clk), .wr_en(a_wr_lanes[l]),
      .own_addr(a_addr), .peer_addr(b_addr),
      .wr_data(a_wdata[l*LANE_W +: LANE_W]), .peer_tag_at_own(tb_peer[l]),
      .own_data(da_own[l*LANE_W +: LANE_W]), .own_tag(ta_own[l]),
      .peer_data(da_peer[l*LANE_W +: LANE_W]), .peer_tag(ta_peer[l])
    );

    dpbr_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .INVERT_TAG(1'b1)) u_bank_b (
      .clk(b_clk), .wr_en(b_wr_lanes[l]),
      .own_addr(b_addr), .peer_addr(a_addr),
      .wr_data(b_wdata[l*LANE_W +: LANE_W]), .peer_tag_at_own(ta_peer[l]),
      .own_data(db_own[l*LANE_W +: LANE_W]), .own_tag(tb_own[l]),
      .peer_data(db_peer[l*LANE_W +: LANE_W]), .peer_tag(tb_peer[l])
    );

    assign a_word[l*LANE_W +: LANE_W] = dpbr_pkg::a_copy_newest(ta_own[l], tb_peer[l])
                                        ? da_own[l*LANE_W +: LANE_W]
                                        : db_peer[l*LANE_W +: LANE_W];
    assign b_word[l*LANE_W +: LANE_W] = dpbr_pkg::a_copy_newest(ta_peer[l], tb_own[l])
                                        ? da_peer[l*LANE_W +: LANE_W]
                                        : db_own[l*LANE_W +: LANE_W];
  end

  dpbr_read_pipe #(.LANE_W(LANE_W), .LANES(LANES)) u_pipe_a (
    .clk(a_clk), .rd_lanes(a_rd_lanes), .word_in(a_word), .oe_n(a_oe_n),
    .rdata(a_rdata), .drive(a_drive)
  );

  dpbr_read_pipe #(.LANE_W(LANE_W), .LANES(LANES)) u_pipe_b (
    .clk(b_clk), .rd_lanes(b_rd_lanes), .word_in(b_word), .oe_n(b_oe_n),
    .rdata(b_rdata), .drive(b_drive)
  );
endmodule

// File: rtl/dual_lane_ram_chk.sv
module dual_lane_ram_chk #(
  parameter int LANE_W = dpbr_pkg::DEF_LANE_W,
  parameter int LANES  = dpbr_pkg::DEF_LANES,
  localparam int WORD_W = LANE_W * LANES
) (
  input logic              a_clk,
  input logic              a_cs_n,
  input logic              a_cs,
  input logic              a_rnw,
  input logic              a_oe_n,
  input logic [LANES-1:0]  a_lane_en_n,
  input logic [WORD_W-1:0] a_rdata,
  input logic [LANES-1:0]  a_drive,
  input logic              b_clk,
  input logic              b_cs_n,
  input logic              b_cs,
  input logic              b_rnw,
  input logic              b_oe_n,
  input logic [LANES-1:0]  b_lane_en_n,
  input logic [WORD_W-1:0] b_rdata,
  input logic [LANES-1:0]  b_drive
);
  logic armed_a = 1'b0;
  logic armed_b = 1'b0;

  always_ff @(posedge a_clk) armed_a <= 1'b1;
  always_ff @(posedge b_clk) armed_b <= 1'b1;

  assert_a_unselected_quiet_R1: assert property (@(posedge a_clk) disable iff (!armed_a)
    !(a_cs_n == 1'b0 && a_cs == 1'b1) |=> (a_drive == '0));

  assert_b_unselected_quiet_R1: assert property (@(posedge b_clk) disable iff (!armed_b)
    !(b_cs_n == 1'b0 && b_cs == 1'b1) |=> (b_drive == '0));

  assert_a_no_lanes_R3: assert property (@(posedge a_clk) disable iff (!armed_a)
    (a_lane_en_n == '1) |=> (a_drive == '0));

  assert_a_drive_subset_R4: assert property (@(posedge a_clk) disable iff (!armed_a)
    (a_cs_n == 1'b0 && a_cs == 1'b1 && a_rnw) |=> ((a_drive & $past(a_lane_en_n)) == '0));

  assert_a_write_hiz_R6: assert property (@(posedge a_clk) disable iff (!armed_a)
    (a_cs_n == 1'b0 && a_cs == 1'b1 && !a_rnw) |=> (a_drive == '0));

  assert_b_write_hiz_R6: assert property (@(posedge b_clk) disable iff (!armed_b)
    (b_cs_n == 1'b0 && b_cs == 1'b1 && !b_rnw) |=> (b_drive == '0));

  assert_a_oe_blocks_R7: assert property (@(posedge a_clk) disable iff (!armed_a)
    a_oe_n |-> (a_drive == '0));

  assert_b_oe_blocks_R7: assert property (@(posedge b_clk) disable iff (!armed_b)
    b_oe_n |-> (b_drive == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assert_a_idle_lane_zero_R5: assert property (@(posedge a_clk) disable iff (!armed_a)
      !a_drive[l] |-> (a_rdata[l*LANE_W +: LANE_W] == '0));
    assert_b_idle_lane_zero_R5: assert property (@(posedge b_clk) disable iff (!armed_b)
      !b_drive[l] |-> (b_rdata[l*LANE_W +: LANE_W] == '0));
  end
endmodule

bind dual_lane_ram dual_lane_ram_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/test_dual_lane_ram.sv
module test_dual_lane_ram;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        a_cs_n, a_cs, a_rnw, a_oe_n, b_cs_n, b_cs, b_rnw, b_oe_n;
  logic [1:0]  a_lane_en_n, b_lane_en_n, a_drive, b_drive;
  logic [AW-1:0] a_addr, b_addr;
  logic [17:0] a_wdata, b_wdata, a_rdata, b_rdata;

  dual_lane_ram i_dual_lane_ram (
    .a_clk(clk), .a_cs_n(a_cs_n), .a_cs(a_cs), .a_rnw(a_rnw), .a_oe_n(a_oe_n),
    .a_lane_en_n(a_lane_en_n), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(clk), .b_cs_n(b_cs_n), .b_cs(b_cs), .b_rnw(b_rnw), .b_oe_n(b_oe_n),
    .b_lane_en_n(b_lane_en_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_drive(b_drive)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [17:0] ref_mem [DEPTH];
  logic [1:0]  exp_a_lanes = 2'b00, exp_b_lanes = 2'b00;
  logic [17:0] exp_a_word = '0, exp_b_word = '0;

  task automatic check(string tag, string what, logic [19:0] got, logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [19:0] expect_out(logic [1:0] lanes, logic oe_n, logic [17:0] w);
    logic [1:0]  d;
    logic [17:0] r;
    d = oe_n ? 2'b00 : lanes;
    r = {d[1] ? w[17:9] : 9'h0, d[0] ? w[8:0] : 9'h0};
    return {d, r};
  endfunction

  task automatic compare();
    check(cur_tag, "port A", {a_drive, a_rdata}, expect_out(exp_a_lanes, a_oe_n, exp_a_word));
    check(cur_tag, "port B", {b_drive, b_rdata}, expect_out(exp_b_lanes, b_oe_n, exp_b_word));
  endtask

  // One clock: the reference model samples the inputs just after the edge,
  // and the outputs are compared at the following falling edge.
  task automatic cycle();
    logic sa, sb;
    @(posedge clk);
    #1;
    sa = (a_cs_n === 1'b0) && (a_cs === 1'b1);
    sb = (b_cs_n === 1'b0) && (b_cs === 1'b1);
    exp_a_lanes = (sa && a_rnw) ? ~a_lane_en_n : 2'b00;
    exp_b_lanes = (sb && b_rnw) ? ~b_lane_en_n : 2'b00;
    exp_a_word = ref_mem[a_addr];
    exp_b_word = ref_mem[b_addr];
    if (sa && !a_rnw) begin
      if (!a_lane_en_n[0]) ref_mem[a_addr][8:0]  = a_wdata[8:0];
      if (!a_lane_en_n[1]) ref_mem[a_addr][17:9] = a_wdata[17:9];
    end
    if (sb && !b_rnw) begin
      if (!b_lane_en_n[0]) ref_mem[b_addr][8:0]  = b_wdata[8:0];
      if (!b_lane_en_n[1]) ref_mem[b_addr][17:9] = b_wdata[17:9];
    end
    @(negedge clk);
    compare();
  endtask

  task automatic set_a(logic cs_n, logic cs, logic rnw, logic [1:0] en_n, logic [AW-1:0] ad, logic [17:0] wd);
    a_cs_n = cs_n; a_cs = cs; a_rnw = rnw; a_lane_en_n = en_n; a_addr = ad; a_wdata = wd;
  endtask

  task automatic set_b(logic cs_n, logic cs, logic rnw, logic [1:0] en_n, logic [AW-1:0] ad, logic [17:0] wd);
    b_cs_n = cs_n; b_cs = cs; b_rnw = rnw; b_lane_en_n = en_n; b_addr = ad; b_wdata = wd;
  endtask

  task automatic idle_both();
    set_a(1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
    set_b(1'b1, 1'b0, 1'b1, 2'b11, 8'd1, '0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R4 watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    idle_both();

    // Idle start: nothing driven (R1).
    cur_tag = "R1";
    cycle(); cycle();

    // Full write then read on port A (R2, R4).
    cur_tag = "R2";
    set_a(1'b0, 1'b1, 1'b0, 2'b00, 8'd5, 18'h3A5C3); cycle();
    cur_tag = "R4";
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd5, '0); cycle();
    cur_tag = "R4";
    set_a(1'b0, 1'b1, 1'b1, 2'b10, 8'd5, '0); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b01, 8'd5, '0); cycle();

    // Lower-only and upper-only writes (R2).
    cur_tag = "R2";
    set_a(1'b0, 1'b1, 1'b0, 2'b10, 8'd5, 18'h00011); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd5, '0); cycle();
    set_b(1'b0, 1'b1, 1'b0, 2'b01, 8'd6, 18'h2AA00); cycle();
    set_b(1'b0, 1'b1, 1'b1, 2'b00, 8'd6, '0); cycle();

    // No lanes enabled: write ignored and read drives nothing (R3).
    cur_tag = "R3";
    set_b(1'b0, 1'b1, 1'b0, 2'b11, 8'd6, 18'h3FFFF); cycle();
    set_b(1'b0, 1'b1, 1'b1, 2'b11, 8'd6, '0); cycle();
    set_b(1'b0, 1'b1, 1'b1, 2'b00, 8'd6, '0); cycle();

    // Either select inactive: write ignored, read drives nothing (R1).
    cur_tag = "R1";
    set_a(1'b1, 1'b1, 1'b0, 2'b00, 8'd5, 18'h12345); cycle();
    set_a(1'b0, 1'b0, 1'b0, 2'b00, 8'd5, 18'h12345); cycle();
    set_a(1'b1, 1'b0, 1'b1, 2'b00, 8'd5, '0); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd5, '0); cycle();

    // A write right after a read turns the outputs off (R6).
    cur_tag = "R6";
    set_a(1'b0, 1'b1, 1'b0, 2'b00, 8'd7, 18'h0F0F0); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd7, '0); cycle();

    // Asynchronous output enable (R7).
    cur_tag = "R7";
    a_oe_n = 1'b1; #1; compare();
    a_oe_n = 1'b0; #1; compare();
    b_oe_n = 1'b1; set_b(1'b0, 1'b1, 1'b1, 2'b00, 8'd6, '0); cycle();
    b_oe_n = 1'b0; #1; compare();

    // Writes from both ports to one word at different edges (R8).
    cur_tag = "R8";
    set_b(1'b1, 1'b0, 1'b1, 2'b11, 8'd1, '0);
    set_a(1'b0, 1'b1, 1'b0, 2'b00, 8'd9, 18'h1B2C3); cycle();
    set_a(1'b1, 1'b0, 1'b1, 2'b11, 8'd0, '0);
    set_b(1'b0, 1'b1, 1'b0, 2'b01, 8'd9, 18'h3FE00); cycle();
    set_b(1'b1, 1'b0, 1'b1, 2'b11, 8'd1, '0); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd9, '0);
    set_b(1'b0, 1'b1, 1'b1, 2'b00, 8'd9, '0); cycle();

    // Simultaneous writes to different words, then crossed reads (R9).
    cur_tag = "R9";
    set_a(1'b0, 1'b1, 1'b0, 2'b00, 8'd20, 18'h15555);
    set_b(1'b0, 1'b1, 1'b0, 2'b00, 8'd21, 18'h2AAAA); cycle();
    set_a(1'b0, 1'b1, 1'b1, 2'b00, 8'd21, '0);
    set_b(1'b0, 1'b1, 1'b1, 2'b00, 8'd20, '0); cycle();

    // Mixed random traffic on both ports, never colliding on a word (R9).
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] aa, ba;
      aa = AW'($urandom_range(0, 31));
      ba = AW'($urandom_range(0, 31));
      if (ba == aa) ba = aa ^ AW'(1);
      set_a(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) != 0),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), aa, 18'($urandom));
      set_b(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) != 0),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), ba, 18'($urandom));
      a_oe_n = 1'($urandom_range(0, 4) == 0);
      b_oe_n = 1'($urandom_range(0, 4) == 0);
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule